// File: doc/BRIEF.md
# Bus Lock-Up Notification Controller

This block gathers already-qualified "stuck" flags from eight downstream bus segments and turns them into an 8-bit indication value that a host can read, along with an active-low interrupt line. Lock-up detection itself is done elsewhere. Each `stuckIn` bit arrives here as a clean level, where 1 means the matching segment is locked up.

A configuration byte controls the block. It enables or disables the interrupt and chooses how the interrupt is released: either when the host reads the indication register, or after a fixed interval of about 1.6 s. It also chooses whether the indication bits follow the inputs live or stay latched until read, and it can turn off notification entirely.

The host reaches the two registers through a plain strobe interface. `regSel` picks the register (0 = configuration, 1 = indication). `wrStrobe` writes the configuration byte. `rdStrobe` marks a read, and reading the indication register has side effects. `rdData` always shows the selected register.

Top module: `lockup_notify`

## Requirements
- R1: After reset the configuration byte reads 0x00, the indication register reads 0x00 and `intN` is high.
- R2: A write with `regSel`=0 stores all eight bits of `wrData`, and they read back unchanged at `regSel`=0 after the write edge.
- R3: With configuration bit 3 clear, indication bit n equals `stuckIn[n]` as captured at the previous clock edge (bit n at 1 means channel n is stuck).
- R4: With configuration bit 3 set, an indication bit that was seen at 1 stays at 1 after its input returns to 0, until the register is read.
- R5: A read strobe with `regSel`=1 in sticky mode clears only the bits whose input is 0 at that read. Bits whose input is still 1 remain set.
- R6: With configuration bit 5 set, the indication register reads 0x00 and `intN` stays high whatever `stuckIn` does.
- R7: With configuration bit 0 clear, `intN` stays high.
- R8: With configuration bit 0 set, a 0-to-1 change on any `stuckIn` bit drives `intN` low two clock edges later. An input held high does not assert it again.
- R9: With configuration bit 2 clear, a read strobe with `regSel`=1 releases `intN` at that edge. A read with `regSel`=0 does not release it.
- R10: With configuration bits 0 and 2 set, `intN` stays low for exactly the release interval (CLK_FREQ_HZ/10 × RELEASE_DECISEC cycles), and reads do not shorten it.
- R11: A new rising stuck flag at the same edge as a release keeps `intN` low. In timed mode it restarts the interval.
- R12: Clearing configuration bit 0 while the interrupt is asserted drives `intN` high two edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stuckIn | input | 8 | Qualified per-channel lock-up flags |
| regSel | input | 1 | Register select: 0 configuration, 1 indication |
| wrStrobe | input | 1 | Configuration write strobe |
| wrData | input | 8 | Configuration write data |
| rdStrobe | input | 1 | Read strobe (side effects on the indication register) |
| rdData | output | 8 | Selected register contents |
| intN | output | 1 | Active-low interrupt |

## Verification
Two events can land on the same clock edge: a host read that releases the interrupt, or a timer expiry, and a fresh rising stuck flag on another channel. The bench provokes this by raising a second channel one edge before issuing the read, so the rise and the read meet at one edge. It then checks that `intN` remains low and that a later read still releases it. In timed mode the bench raises a second channel halfway through the interval and checks that the total low time equals the delay to the retrigger plus one full interval.

// File: rtl/lockup_notify_pkg.sv
package lockup_notify_pkg;

  // configuration bit positions; software encodes these
  localparam int CFG_INT_EN_BIT     = 0;
  localparam int CFG_TIMED_BIT      = 2;
  localparam int CFG_STICKY_BIT     = 3;
  localparam int CFG_DETECT_OFF_BIT = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic indRd;
  } hostStrobe_t;

  // decoded configuration fields
  typedef struct packed {
    logic intEn;
    logic timedRelease;
    logic stickyMode;
    logic detectOff;
  } cfgView_t;

endpackage

// File: rtl/lockup_notify_datapath.sv
module lockup_notify_datapath
  import lockup_notify_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] stuckIn,
  output cfgView_t          cfgView,
  output logic              riseAny,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cfgReg;
  logic [NUM_CH-1:0] stuckQ;
  logic [NUM_CH-1:0] flagsPrev;
  logic [NUM_CH-1:0] liveFlags;
  logic [NUM_CH-1:0] stickyQ;
  logic [NUM_CH-1:0] riseVec;
  logic [NUM_CH-1:0] indValue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (strobe.cfgWr) begin
      cfgReg <= wrData;
    end
  end

  assign cfgView.intEn        = cfgReg[CFG_INT_EN_BIT];
  assign cfgView.timedRelease = cfgReg[CFG_TIMED_BIT];
  assign cfgView.stickyMode   = cfgReg[CFG_STICKY_BIT];
  assign cfgView.detectOff    = cfgReg[CFG_DETECT_OFF_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stuckQ    <= '0;
      flagsPrev <= '0;
    end else begin
      stuckQ    <= stuckIn;
      flagsPrev <= liveFlags;
    end
  end

  assign liveFlags = cfgView.detectOff ? '0 : stuckQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stickyQ[g] <= 1'b0;
      end else if (!cfgView.stickyMode || cfgView.detectOff) begin
        stickyQ[g] <= 1'b0;
      end else if (strobe.indRd) begin
        stickyQ[g] <= liveFlags[g];
      end else begin
        stickyQ[g] <= stickyQ[g] | liveFlags[g];
      end
    end

    assign riseVec[g]  = liveFlags[g] & ~flagsPrev[g];
    assign indValue[g] = cfgView.stickyMode ? (stickyQ[g] | liveFlags[g]) : liveFlags[g];
  end

  assign riseAny = |riseVec;
  assign rdData  = regSel ? DATA_W'(indValue) : cfgReg;

  // R4: sticky bits never drop without a read
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgView.stickyMode && !cfgView.detectOff && !strobe.indRd)
      |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  // R5: a read keeps exactly the channels still stuck
  assert_read_trim_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgView.stickyMode && !cfgView.detectOff && strobe.indRd)
      |=> (stickyQ == $past(liveFlags)));

  // R6: detection off empties the sticky store
  assert_disabled_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgView.detectOff |=> (stickyQ == '0));

endmodule

// File: rtl/lockup_notify_ctrl.sv
module lockup_notify_ctrl
  import lockup_notify_pkg::*;
#(
  parameter int CLK_FREQ_HZ     = 200_000_000,
  parameter int RELEASE_DECISEC = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        wrStrobe,
  input  logic        rdStrobe,
  input  cfgView_t    cfgView,
  input  logic        riseAny,
  output hostStrobe_t strobe,
  output logic        intN
);

  localparam int TIMEOUT_CYCLES = (CLK_FREQ_HZ / 10) * RELEASE_DECISEC;
  localparam int TMR_W          = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic             intActive;
  logic [TMR_W-1:0] timerQ;
  logic             timerDone;
  logic             readRelease;

  assign strobe.cfgWr = wrStrobe & ~regSel;
  assign strobe.indRd = rdStrobe & regSel;

  assign timerDone   = intActive && cfgView.timedRelease && (timerQ == TMR_LAST);
  assign readRelease = intActive && !cfgView.timedRelease && strobe.indRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intActive <= 1'b0;
      timerQ    <= '0;
    end else if (!cfgView.intEn || cfgView.detectOff) begin
      intActive <= 1'b0;
      timerQ    <= '0;
    end else if (riseAny) begin
      intActive <= 1'b1;
      timerQ    <= '0;
    end else if (timerDone || readRelease) begin
      intActive <= 1'b0;
      timerQ    <= '0;
    end else if (intActive && cfgView.timedRelease) begin
      timerQ    <= timerQ + 1'b1;
    end
  end

  assign intN = ~intActive;

  // R7 / R12: interrupt disabled forces release
  assert_int_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgView.intEn |=> !intActive);

  // R8: an enabled rising flag asserts the interrupt
  assert_rise_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (riseAny && cfgView.intEn) |=> intActive);

  // R9: a read of the indication register releases in clear-on-read mode
  assert_read_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intActive && cfgView.intEn && !cfgView.detectOff && !cfgView.timedRelease
     && strobe.indRd && !riseAny) |=> !intActive);

  // R10: reads never release in timed mode
  assert_timed_ignores_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intActive && cfgView.intEn && !cfgView.detectOff && cfgView.timedRelease
     && (timerQ != TMR_LAST)) |=> intActive);

  // R6: detection off never leaves the interrupt asserted
  assert_detect_off_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgView.detectOff |=> !intActive);

endmodule

// File: rtl/lockup_notify.sv
module lockup_notify
  import lockup_notify_pkg::*;
#(
  parameter int NUM_CH          = 8,
  parameter int DATA_W          = 8,
  parameter int CLK_FREQ_HZ     = 200_000_000,
  parameter int RELEASE_DECISEC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] stuckIn,
  input  logic              regSel,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              intN
);

  hostStrobe_t strobe;
  cfgView_t    cfgView;
  logic        riseAny;

  lockup_notify_ctrl #(
    .CLK_FREQ_HZ    (CLK_FREQ_HZ),
    .RELEASE_DECISEC(RELEASE_DECISEC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regSel  (regSel),
    .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe),
    .cfgView (cfgView),
    .riseAny (riseAny),
    .strobe  (strobe),
    .intN    (intN)
  );

  lockup_notify_datapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .regSel (regSel),
    .wrData (wrData),
    .stuckIn(stuckIn),
    .cfgView(cfgView),
    .riseAny(riseAny),
    .rdData (rdData)
  );

endmodule

// File: tb/tb_lockup_notify.sv
`timescale 1ns/1ps
module tb_lockup_notify;

  localparam int CLK_HZ  = 50;
  localparam int TIMEOUT = (CLK_HZ / 10) * 16;  // 80 cycles

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] stuckIn = '0;
  logic       regSel = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       intN;

  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  lockup_notify #(
    .CLK_FREQ_HZ(CLK_HZ)
  ) dut (
    .clk(clk), .rstN(rstN), .stuckIn(stuckIn), .regSel(regSel),
    .wrStrobe(wrStrobe), .wrData(wrData), .rdStrobe(rdStrobe),
    .rdData(rdData), .intN(intN)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [7:0] v);
    regSel = 1'b0; wrData = v; wrStrobe = 1'b1;
    tick();
    wrStrobe = 1'b0;
  endtask

  task automatic readInd();
    regSel = 1'b1; rdStrobe = 1'b1;
    tick();
    rdStrobe = 1'b0;
  endtask

  task automatic settle();
    stuckIn = '0;
    writeCfg(8'h00);
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    regSel = 1'b0; #0.1;
    check("R1 cfg", rdData, 0);
    regSel = 1'b1; #0.1;
    check("R1 ind", rdData, 0);
    check("R1 intN", intN, 1);

    // R2 config sweep
    for (int v = 0; v < 256; v++) begin
      writeCfg(8'(v));
      check("R2 readback", rdData, v);
    end
    settle();

    // R3 live sweep, R7 interrupt disabled
    for (int p = 0; p < 256; p++) begin
      stuckIn = 8'(p);
      regSel = 1'b1;
      tick();
      check("R3 live", rdData, p);
      check("R7 intN", intN, 1);
    end
    settle();

    // R6 detection disabled
    writeCfg(8'h21);
    for (int p = 0; p < 256; p += 7) begin
      stuckIn = 8'(p);
      regSel = 1'b1;
      tick(); tick();
      check("R6 ind", rdData, 0);
      check("R6 intN", intN, 1);
    end
    settle();
    writeCfg(8'h28);
    stuckIn = 8'hFF; regSel = 1'b1;
    tick(); tick();
    check("R6 sticky ind", rdData, 0);
    settle();

    // R8 / R9 clear-on-read, per channel
    writeCfg(8'h01);
    tick(); tick();
    for (int n = 0; n < 8; n++) begin
      stuckIn = 8'(1 << n);
      tick();
      check("R8 not yet", intN, 1);
      tick();
      check("R8 asserted", intN, 0);
      regSel = 1'b0; rdStrobe = 1'b1; tick(); rdStrobe = 1'b0;
      check("R9 cfg read keeps", intN, 0);
      readInd();
      check("R9 released", intN, 1);
      tick(); tick(); tick();
      check("R8 level no reassert", intN, 1);
      stuckIn = '0;
      tick(); tick();
    end

    // R11 rise coincides with release read
    stuckIn = 8'h01;
    tick(); tick();
    check("R11 pre", intN, 0);
    stuckIn = 8'h03;
    tick();
    readInd();
    check("R11 rise wins", intN, 0);
    readInd();
    check("R11 later read", intN, 1);
    settle();

    // R12 clearing enable releases
    writeCfg(8'h01);
    stuckIn = 8'h80;
    tick(); tick();
    check("R12 pre", intN, 0);
    writeCfg(8'h00);
    tick();
    check("R12 released", intN, 1);
    settle();

    // R10 timed release length
    writeCfg(8'h05);
    stuckIn = 8'h01;
    tick(); tick();
    begin
      int cnt = 0;
      while (intN == 1'b0 && cnt < 1000) begin
        cnt++;
        tick();
      end
      check("R10 low cycles", cnt, TIMEOUT);
    end
    stuckIn = '0; tick(); tick();

    // R10 reads ignored in timed mode
    stuckIn = 8'h10;
    tick(); tick();
    readInd();
    check("R10 read ignored", intN, 0);
    repeat (TIMEOUT + 2) tick();
    check("R10 expired", intN, 1);
    stuckIn = '0; tick(); tick();

    // R11 retrigger in timed mode
    stuckIn = 8'h01;
    tick(); tick();
    begin
      int cnt = 0;
      while (intN == 1'b0 && cnt < 1000) begin
        cnt++;
        if (cnt == 40) stuckIn = 8'h03;
        tick();
      end
      check("R11 retrigger cycles", cnt, 41 + TIMEOUT);
    end
    settle();

    // R4 / R5 sticky sweep
    writeCfg(8'h08);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        int p = i * 16 + j;
        int q = j * 16 + i;
        stuckIn = 8'(p); regSel = 1'b1;
        tick();
        stuckIn = 8'(q);
        tick();
        check("R4 latched", rdData, p | q);
        readInd();
        check("R5 trimmed", rdData, q);
        stuckIn = '0;
        tick();
        readInd();
      end
    end
    check("R5 emptied", rdData, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule